// File: doc/BRIEF.md
# Bus-Side Shadow Coherence Directory

This block keeps a compact copy of the coherence state of every cache line of local memory, at two bits per line. A snoop on the pipelined split-transaction node bus can then be answered within one cycle, without a read of the full sharer bitmap, which lives in slower storage elsewhere. Lookups arrive on a bus-facing port that gives a line address and a read or read-exclusive flag. The block returns the stored state and a response class. The class tells the bus interface whether local memory can answer on its own or whether the request has to go to a protocol engine.

A separate write port keeps the copy in step with the full directory. The directory access logic drives this port each time it changes a line's state. An update is applied at the next clock edge. When an update and a lookup hit the same line in the same cycle, the lookup sees the updated value. Lookups are paced at one every two bus cycles to suit the bus pipeline. A ready output shows when a lookup will be taken.

Top module: `shadow_dir`

## Requirements
- R1: After reset every line holds state 00 (no remote copy), `lkp_ready_o` is 1 and `lkp_done_o` is 0.
- R2: After a lookup is accepted (`lkp_valid_i` and `lkp_ready_o` both high at a clock edge), `lkp_ready_o` is 0 for the next cycle. A lookup presented while `lkp_ready_o` is 0 is dropped and produces no result.
- R3: An accepted lookup raises `lkp_done_o` for exactly one cycle, in the cycle after acceptance, and `lkp_state_o` then shows that line's state. The line is chosen by address bits [12:7]. Bits [6:0] are the byte offset within a 128-byte line and have no effect.
- R4: If an update and an accepted lookup name the same line in the same cycle, the lookup returns the state that the update writes.
- R5: An update with `upd_valid_i` high stores `upd_state_i` for the addressed line, and later lookups read it back. No other line changes.
- R6: State 00 (no remote copy) gives class 00 (local memory answers) and `lkp_engine_o` = 0, whatever `lkp_excl_i` is.
- R7: State 01 (shared at remote nodes) gives class 00 with `lkp_engine_o` = 0 for a read (`lkp_excl_i` = 0). For a read-exclusive it gives class 01 (memory answers, engine invalidates sharers) with `lkp_engine_o` = 1.
- R8: State 10 (dirty at a remote node) gives class 10 and state 11 (transaction pending) gives class 11. Both set `lkp_engine_o` = 1, so the request is forwarded to a protocol engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request present |
| lkp_addr_i | input | 13 | Lookup byte address |
| lkp_excl_i | input | 1 | Lookup is read-exclusive |
| lkp_ready_o | output | 1 | A lookup will be accepted this cycle |
| lkp_done_o | output | 1 | Lookup result valid |
| lkp_state_o | output | 2 | State of the looked-up line |
| lkp_class_o | output | 2 | Response class |
| lkp_engine_o | output | 1 | Request needs a protocol engine |
| upd_valid_i | input | 1 | Update write enable |
| upd_addr_i | input | 13 | Update byte address |
| upd_state_i | input | 2 | New state for the line |

## Verification
The assertions assume that the update port carries at most one write per cycle. They also assume that the directory access logic never leaves `upd_state_i` or the address undefined while `upd_valid_i` is high. The pacing assertions take the ready signal as the only gate on the lookup port. The stimulus therefore drives lookups only after observing ready, except in the one deliberate drop case. Every update there carries a defined two-bit value. Byte offsets are varied on both ports so that any dependence on them would be visible.

// File: rtl/shadow_dir_pkg.sv
package shadow_dir_pkg;

  typedef enum logic [1:0] {
    ST_NONE   = 2'b00,
    ST_SHARED = 2'b01,
    ST_DIRTY  = 2'b10,
    ST_BUSY   = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    CL_MEM       = 2'b00,
    CL_MEM_INVAL = 2'b01,
    CL_FWD_DIRTY = 2'b10,
    CL_FWD_BUSY  = 2'b11
  } resp_cls_e;

endpackage

// File: rtl/shadow_dir_array.sv
module shadow_dir_array #(
  parameter int LINES = 64,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [1:0]       wr_state_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [1:0]       rd_state_o
);

  logic [1:0] rows_q [LINES];

  for (genvar r = 0; r < LINES; r++) begin : g_row
    logic row_we;
    assign row_we = wr_en_i && (wr_idx_i == IDX_W'(r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     rows_q[r] <= 2'b00;
      else if (row_we) rows_q[r] <= wr_state_i;
    end
  end

  assign rd_state_o = rows_q[rd_idx_i];

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rows_q[$past(wr_idx_i)] == $past(wr_state_i)); // R5

endmodule

// File: rtl/shadow_dir_pacer.sv
module shadow_dir_pacer #(
  parameter int GAP = 2,
  localparam int CNT_W = $clog2(GAP + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic ready_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (fire_i)        cnt_q <= CNT_W'(GAP - 1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0);

  AST_READY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> !ready_o); // R2

endmodule

// File: rtl/shadow_dir_classify.sv
module shadow_dir_classify
  import shadow_dir_pkg::*;
(
  input  logic [1:0] state_i,
  input  logic       excl_i,
  output logic [1:0] cls_o,
  output logic       engine_o
);

  resp_cls_e cls;

  always_comb begin
    unique case (line_st_e'(state_i))
      ST_NONE:   cls = CL_MEM;
      ST_SHARED: cls = excl_i ? CL_MEM_INVAL : CL_MEM;
      ST_DIRTY:  cls = CL_FWD_DIRTY;
      ST_BUSY:   cls = CL_FWD_BUSY;
      default:   cls = CL_FWD_BUSY;
    endcase
  end

  assign cls_o    = cls;
  assign engine_o = (cls != CL_MEM);

endmodule

// File: rtl/shadow_dir.sv
module shadow_dir #(
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 128,
  parameter int LKP_GAP    = 2,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int ADDR_W = OFF_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [ADDR_W-1:0] lkp_addr_i,
  input  logic              lkp_excl_i,
  output logic              lkp_ready_o,
  output logic              lkp_done_o,
  output logic [1:0]        lkp_state_o,
  output logic [1:0]        lkp_class_o,
  output logic              lkp_engine_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic [1:0]        upd_state_i
);

  logic [IDX_W-1:0] lkp_idx, upd_idx;
  logic [1:0]       arr_state, eff_state, cls_d;
  logic             lkp_fire, upd_hit, eng_d;
  logic             unused_offset;

  assign lkp_idx       = lkp_addr_i[ADDR_W-1:OFF_W];
  assign upd_idx       = upd_addr_i[ADDR_W-1:OFF_W];
  assign unused_offset = ^{lkp_addr_i[OFF_W-1:0], upd_addr_i[OFF_W-1:0]};

  shadow_dir_pacer #(.GAP(LKP_GAP)) u_pacer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (lkp_fire),
    .ready_o (lkp_ready_o)
  );

  assign lkp_fire = lkp_valid_i & lkp_ready_o;

  shadow_dir_array #(.LINES(LINES)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (upd_idx),
    .wr_state_i (upd_state_i),
    .rd_idx_i   (lkp_idx),
    .rd_state_o (arr_state)
  );

  // same-cycle update wins over the stored value
  assign upd_hit   = upd_valid_i && (upd_idx == lkp_idx);
  assign eff_state = upd_hit ? upd_state_i : arr_state;

  shadow_dir_classify u_cls (
    .state_i  (eff_state),
    .excl_i   (lkp_excl_i),
    .cls_o    (cls_d),
    .engine_o (eng_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lkp_done_o   <= 1'b0;
      lkp_state_o  <= 2'b00;
      lkp_class_o  <= 2'b00;
      lkp_engine_o <= 1'b0;
    end else begin
      lkp_done_o <= lkp_fire;
      if (lkp_fire) begin
        lkp_state_o  <= eff_state;
        lkp_class_o  <= cls_d;
        lkp_engine_o <= eng_d;
      end
    end
  end

  AST_ONE_PER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_done_o |=> !lkp_done_o); // R2
  AST_RESULT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && lkp_ready_o) |=> lkp_done_o); // R3
  AST_COLLIDE_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && lkp_ready_o && upd_valid_i &&
     upd_addr_i[ADDR_W-1:OFF_W] == lkp_addr_i[ADDR_W-1:OFF_W])
    |=> lkp_state_o == $past(upd_state_i)); // R4
  AST_NONE_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_done_o && lkp_state_o == 2'b00) |-> (lkp_class_o == 2'b00 && !lkp_engine_o)); // R6
  AST_FWD_ENGINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_done_o && lkp_state_o[1]) |-> (lkp_engine_o && lkp_class_o == lkp_state_o)); // R8

endmodule

// File: tb/shadow_dir_bench.sv
module shadow_dir_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 64;
  localparam int AW = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lkp_valid = 0, lkp_excl = 0, upd_valid = 0;
  logic [AW-1:0] lkp_addr = '0, upd_addr = '0;
  logic [1:0] upd_state = '0;
  logic lkp_ready, lkp_done, lkp_engine;
  logic [1:0] lkp_state, lkp_class;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_dir u_shadow_dir (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_addr_i(lkp_addr), .lkp_excl_i(lkp_excl),
    .lkp_ready_o(lkp_ready), .lkp_done_o(lkp_done), .lkp_state_o(lkp_state),
    .lkp_class_o(lkp_class), .lkp_engine_o(lkp_engine),
    .upd_valid_i(upd_valid), .upd_addr_i(upd_addr), .upd_state_i(upd_state)
  );

  function automatic logic [1:0] pattern(int i);
    return 2'((i + (i >> 3)) & 3);
  endfunction

  function automatic logic [1:0] exp_cls(logic [1:0] st, logic ex);
    if (st == 2'b00) return 2'b00;
    if (st == 2'b01) return ex ? 2'b01 : 2'b00;
    return st;
  endfunction

  function automatic logic [AW-1:0] mk_addr(int line, int off);
    return AW'((line << 7) | (off & 127));
  endfunction

  task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // result packed as {done, state, class, engine}
  function automatic logic [7:0] observed();
    return {2'b0, lkp_done, lkp_state, lkp_class, lkp_engine};
  endfunction

  function automatic logic [7:0] expected(logic [1:0] st, logic ex);
    logic [1:0] c;
    c = exp_cls(st, ex);
    return {2'b0, 1'b1, st, c, (c != 2'b00)};
  endfunction

  task automatic lookup_check(int line, logic ex, int off, logic [1:0] st, string req);
    @(negedge clk);
    check(lkp_ready === 1'b1, {req, " ready"}, {7'b0, lkp_ready}, 8'h1);
    lkp_valid = 1; lkp_addr = mk_addr(line, off); lkp_excl = ex;
    @(negedge clk);
    lkp_valid = 0;
    check(observed() === expected(st, ex), req, observed(), expected(st, ex));
  endtask

  task automatic update(int line, int off, logic [1:0] st);
    @(negedge clk);
    upd_valid = 1; upd_addr = mk_addr(line, off); upd_state = st;
    @(negedge clk);
    upd_valid = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset outputs
    check(lkp_ready === 1'b1, "R1 ready", {7'b0, lkp_ready}, 8'h1);
    check(lkp_done === 1'b0, "R1 done", {7'b0, lkp_done}, 8'h0);
    rst_n = 1;
    // R1 R6: every line reads 00 after reset, offset varied
    for (int i = 0; i < LINES; i++)
      lookup_check(i, 1'(i & 1), i * 37, 2'b00, "R1_R6 reset state");
    // R5: fill with a pattern covering all four states
    for (int i = 0; i < LINES; i++) update(i, i * 11 + 5, pattern(i));
    // R3 R5 R7 R8: read back with read and read-exclusive
    for (int i = 0; i < LINES; i++) begin
      lookup_check(i, 1'b0, 127 - i, pattern(i), "R3_R5_R7_R8 read");
      lookup_check(i, 1'b1, i * 3, pattern(i), "R3_R5_R7_R8 excl");
    end
    // R4: update and lookup same line same cycle
    for (int i = 0; i < 8; i++) begin
      logic [1:0] nv;
      nv = pattern(i) + 2'd1;
      @(negedge clk);
      lkp_valid = 1; lkp_addr = mk_addr(i, 9); lkp_excl = 1'b1;
      upd_valid = 1; upd_addr = mk_addr(i, 100); upd_state = nv;
      @(negedge clk);
      lkp_valid = 0; upd_valid = 0;
      check(observed() === expected(nv, 1'b1), "R4 collide", observed(), expected(nv, 1'b1));
      lookup_check(i, 1'b0, 0, nv, "R4 stored after collide");
    end
    // R5: update a neighbour while looking up: old value, neighbour only changes
    @(negedge clk);
    lkp_valid = 1; lkp_addr = mk_addr(20, 1); lkp_excl = 0;
    upd_valid = 1; upd_addr = mk_addr(21, 1); upd_state = ~pattern(21);
    @(negedge clk);
    lkp_valid = 0; upd_valid = 0;
    check(observed() === expected(pattern(20), 1'b0), "R5 neighbour untouched",
          observed(), expected(pattern(20), 1'b0));
    lookup_check(21, 1'b0, 2, ~pattern(21), "R5 neighbour written");
    lookup_check(20, 1'b0, 3, pattern(20), "R5 line unchanged");
    // R2: back-to-back request; second is dropped
    @(negedge clk);
    lkp_valid = 1; lkp_addr = mk_addr(30, 0); lkp_excl = 0;
    @(negedge clk);
    check(lkp_ready === 1'b0, "R2 ready low", {7'b0, lkp_ready}, 8'h0);
    check(observed() === expected(pattern(30), 1'b0), "R2 first result",
          observed(), expected(pattern(30), 1'b0));
    lkp_addr = mk_addr(31, 0);
    @(negedge clk);
    lkp_valid = 0;
    check(lkp_done === 1'b0, "R2 dropped no result", {7'b0, lkp_done}, 8'h0);
    check(lkp_ready === 1'b1, "R2 ready back", {7'b0, lkp_ready}, 8'h1);
    @(negedge clk);
    check(lkp_done === 1'b0, "R3 single pulse", {7'b0, lkp_done}, 8'h0);
    finish_run();
  end
endmodule